// File: doc/BRIEF.md
# Dot-Row Attribute and Brightness Renderer

This block drives one column group of a four-character dot-matrix display. It owns a scan counter that visits every character position on each of the seven dot rows, a blink timebase, and a pulse-width duty modulator. For the cell being scanned, it sends the stored character code and row number to an external character generator and gets back five column bits. It then decides what the cell shows, applies the control settings, and drives five column bits plus one duty gate. The control settings are brightness, per-character highlight, whole-display blink and lamp test.

The rendering is purely a function of the scan state, the blink phase and the present inputs. Changing a control field never alters the character codes, so turning lamp test or highlighting off shows the plain characters again at once. A synchronous reset returns the scan and blink counters to zero, which lets several modules that share a clock and a reset blink in step.

Top module: `dotrow_renderer`

## Requirements
- R1: Each cycle is one duty phase. A cell lasts PHASES cycles (default 8). Cells advance digit 0 to 3 within a row, and rows advance 0 to 6 and then wrap. Cycle t after reset shows phase t mod 8, digit (t/8) mod 4 and row (t/32) mod 7 on `digit_sel` and `row_sel`.
- R2: `glyph_code` carries bits 6:0 of the scanned digit's code. That code sits in `char_codes[8*d+7:8*d]`. `glyph_row` carries the row. A plain cell drives `glyph_bits` onto `col_drive`.
- R3: The brightness code sets the level L: 11 gives PHASES, 10 gives PHASES/2, 01 gives PHASES/4 and 00 gives 0 (blank). A plain cell raises `duty_gate` while phase < L.
- R4: A character is highlighted only if bit 7 of its code is 1 and `hl_en` is 1. Otherwise it renders plainly.
- R5: A cursor cell drives all five columns at 1, with the gate high while phase < L/2. Highlight mode 00 always shows a cursor.
- R6: A dark cell drives columns 0 and gate 0. Highlight mode 01 shows the character in the visible blink half and a dark cell in the other half.
- R7: Highlight mode 10 shows a cursor in the visible half and a dark cell in the hidden half. Mode 11 shows the character in the visible half and a cursor in the hidden half.
- R8: The blink phase is visible when floor(t / BLINK_DIV) is even. The two halves are of equal length.
- R9: With `blink_all` set, every cell is dark in the hidden half, regardless of bit 7.
- R10: Lamp test drives all columns at 1 with the gate high while phase < PHASES/2, at any brightness code. It overrides blink and highlight.
- R11: Reset returns the scan and blink counters to t = 0.
- R12: Rendering keeps no state from earlier control settings. From the first cycle after a control change, the output follows the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of scan and blink counters |
| char_codes | input | 32 | Four 8-bit stored codes; bit 7 is the highlight flag |
| bright | input | 2 | Brightness code |
| hl_mode | input | 2 | Highlight mode for flagged characters |
| hl_en | input | 1 | Highlight enable |
| blink_all | input | 1 | Whole-display blink |
| lamp_test | input | 1 | Lamp test |
| glyph_code | output | 7 | Character code sent to the character generator |
| glyph_row | output | 3 | Row sent to the character generator |
| glyph_bits | input | 5 | Column pattern returned by the character generator |
| digit_sel | output | 2 | Digit being scanned |
| row_sel | output | 3 | Row being scanned |
| col_drive | output | 5 | Column drive bits |
| duty_gate | output | 1 | Pulse-width gate for the current cycle |

## Verification
A scan counter that slips or wraps early shows up within one cell, eight cycles, as a wrong `digit_sel` or `row_sel`. The lookup port and the column pattern go wrong in the same cycle. A blink counter with the wrong period or phase appears at the first half-period boundary as columns lit or dark in the wrong half. A wrong duty threshold shows up within one cell as a gate high for too many or too few phases. Because outputs are checked every cycle across all control combinations, with resets part-way through, any such divergence is seen within one blink half-period.

// File: rtl/dotrow_pkg.sv
package dotrow_pkg;

    typedef enum logic [1:0] {
        CELL_DARK   = 2'd0,
        CELL_GLYPH  = 2'd1,
        CELL_CURSOR = 2'd2,
        CELL_LAMP   = 2'd3
    } cell_kind_t;

    typedef enum logic [1:0] {
        HL_CURSOR       = 2'd0,
        HL_BLINK_CHAR   = 2'd1,
        HL_BLINK_CURSOR = 2'd2,
        HL_ALTERNATE    = 2'd3
    } hl_mode_t;

    // Number of lit phases per cell for a brightness code.
    function automatic int unsigned level_steps(logic [1:0] code, int unsigned phases);
        case (code)
            2'b11:   return phases;
            2'b10:   return phases / 2;
            2'b01:   return phases / 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dotrow_scan.sv
module dotrow_scan #(
    parameter int PHASES = 8,
    parameter int DIGITS = 4,
    parameter int ROWS   = 7,
    localparam int PW = $clog2(PHASES),
    localparam int DW = $clog2(DIGITS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic [DW-1:0] digit,
    output logic [RW-1:0] row
);
    localparam logic [PW-1:0] P_LAST = PW'(PHASES - 1);
    localparam logic [DW-1:0] D_LAST = DW'(DIGITS - 1);
    localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            digit <= '0;
            row   <= '0;
        end else begin
            phase <= (phase == P_LAST) ? '0 : phase + 1'b1;
            if (phase == P_LAST) begin
                digit <= (digit == D_LAST) ? '0 : digit + 1'b1;
                if (digit == D_LAST)
                    row <= (row == R_LAST) ? '0 : row + 1'b1;
            end
        end
    end

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == P_LAST) |=> (phase == '0));
    p_cell_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (phase != P_LAST) |=> ($stable(digit) && $stable(row)));
    p_row_range_r1: assert property (@(posedge clk) disable iff (rst)
        row <= R_LAST);
    p_reset_zero_r11: assert property (@(posedge clk)
        rst |=> (phase == '0 && digit == '0 && row == '0));
endmodule

// File: rtl/dotrow_blink.sv
module dotrow_blink #(
    parameter int BLINK_DIV = 6_250_000,
    localparam int BW = $clog2(BLINK_DIV)
) (
    input  logic clk,
    input  logic rst,
    output logic visible
);
    localparam logic [BW-1:0] C_LAST = BW'(BLINK_DIV - 1);

    logic [BW-1:0] cnt;
    logic          hidden;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hidden <= 1'b0;
        end else if (cnt == C_LAST) begin
            cnt    <= '0;
            hidden <= ~hidden;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign visible = ~hidden;

    p_half_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt != C_LAST) |=> $stable(hidden));
    p_half_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == C_LAST) |=> (hidden != $past(hidden)));
endmodule

// File: rtl/dotrow_cell.sv
module dotrow_cell
    import dotrow_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int COLS   = 5,
    localparam int DW = $clog2(DIGITS)
) (
    input  logic [DIGITS*8-1:0] char_codes,
    input  logic [DW-1:0]       digit,
    input  logic [1:0]          hl_mode,
    input  logic                hl_en,
    input  logic                blink_all,
    input  logic                lamp_test,
    input  logic                visible,
    input  logic [COLS-1:0]     glyph_bits,
    output logic [6:0]          code_out,
    output cell_kind_t          kind,
    output logic [COLS-1:0]     cols
);
    logic [7:0] code;

    always_comb begin
        code     = char_codes[32'(digit)*8 +: 8];
        code_out = code[6:0];
        if (lamp_test)
            kind = CELL_LAMP;
        else if (blink_all && !visible)
            kind = CELL_DARK;
        else if (code[7] && hl_en) begin
            case (hl_mode_t'(hl_mode))
                HL_CURSOR:       kind = CELL_CURSOR;
                HL_BLINK_CHAR:   kind = visible ? CELL_GLYPH : CELL_DARK;
                HL_BLINK_CURSOR: kind = visible ? CELL_CURSOR : CELL_DARK;
                default:         kind = visible ? CELL_GLYPH : CELL_CURSOR;
            endcase
        end else
            kind = CELL_GLYPH;

        case (kind)
            CELL_GLYPH: cols = glyph_bits;
            CELL_DARK:  cols = '0;
            default:    cols = '1;
        endcase
    end
endmodule

// File: rtl/dotrow_duty.sv
module dotrow_duty
    import dotrow_pkg::*;
#(
    parameter int PHASES = 8,
    localparam int PW = $clog2(PHASES)
) (
    input  logic [PW-1:0] phase,
    input  logic [1:0]    bright,
    input  cell_kind_t    kind,
    output logic          gate
);
    int unsigned thr;

    always_comb begin
        case (kind)
            CELL_GLYPH:  thr = level_steps(bright, PHASES);
            CELL_CURSOR: thr = level_steps(bright, PHASES) / 2;
            CELL_LAMP:   thr = PHASES / 2;
            default:     thr = 0;
        endcase
        gate = 32'(phase) < thr;
    end
endmodule

// File: rtl/dotrow_renderer.sv
module dotrow_renderer
    import dotrow_pkg::*;
#(
    parameter int PHASES    = 8,
    parameter int DIGITS    = 4,
    parameter int ROWS      = 7,
    parameter int COLS      = 5,
    parameter int BLINK_DIV = 6_250_000,
    localparam int PW = $clog2(PHASES),
    localparam int DW = $clog2(DIGITS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIGITS*8-1:0] char_codes,
    input  logic [1:0]          bright,
    input  logic [1:0]          hl_mode,
    input  logic                hl_en,
    input  logic                blink_all,
    input  logic                lamp_test,
    output logic [6:0]          glyph_code,
    output logic [RW-1:0]       glyph_row,
    input  logic [COLS-1:0]     glyph_bits,
    output logic [DW-1:0]       digit_sel,
    output logic [RW-1:0]       row_sel,
    output logic [COLS-1:0]     col_drive,
    output logic                duty_gate
);
    logic [PW-1:0] phase;
    logic          visible;
    cell_kind_t    kind;

    dotrow_scan #(.PHASES(PHASES), .DIGITS(DIGITS), .ROWS(ROWS)) u_scan (
        .clk(clk), .rst(rst), .phase(phase), .digit(digit_sel), .row(row_sel)
    );

    dotrow_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
        .clk(clk), .rst(rst), .visible(visible)
    );

    dotrow_cell #(.DIGITS(DIGITS), .COLS(COLS)) u_cell (
        .char_codes(char_codes), .digit(digit_sel), .hl_mode(hl_mode),
        .hl_en(hl_en), .blink_all(blink_all), .lamp_test(lamp_test),
        .visible(visible), .glyph_bits(glyph_bits), .code_out(glyph_code),
        .kind(kind), .cols(col_drive)
    );

    dotrow_duty #(.PHASES(PHASES)) u_duty (
        .phase(phase), .bright(bright), .kind(kind), .gate(duty_gate)
    );

    assign glyph_row = row_sel;

    p_lamp_all_dots_r10: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> (col_drive == '1));
    p_blank_no_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (bright == 2'b00 && !lamp_test) |-> !duty_gate);
    p_dark_no_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (col_drive == '0 && kind != CELL_GLYPH) |-> !duty_gate);
endmodule

// File: tb/test_dotrow_renderer.sv
`timescale 1ns/1ps
module test_dotrow_renderer;
    localparam int DIV = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] char_codes = '0;
    logic [1:0]  bright = '0, hl_mode = '0;
    logic        hl_en = 0, blink_all = 0, lamp_test = 0;
    logic [6:0]  glyph_code;
    logic [2:0]  glyph_row;
    logic [4:0]  glyph_bits;
    logic [1:0]  digit_sel;
    logic [2:0]  row_sel;
    logic [4:0]  col_drive;
    logic        duty_gate;

    int n_cmp = 0, n_bad = 0, tcnt = 0;

    always #5 clk = ~clk;

    // external character generator model
    assign glyph_bits = glyph_code[4:0] ^ 5'(glyph_row * 5);

    always @(posedge clk) tcnt <= rst ? 0 : tcnt + 1;

    dotrow_renderer #(.BLINK_DIV(DIV)) i_dotrow_renderer (
        .clk(clk), .rst(rst), .char_codes(char_codes), .bright(bright),
        .hl_mode(hl_mode), .hl_en(hl_en), .blink_all(blink_all),
        .lamp_test(lamp_test), .glyph_code(glyph_code), .glyph_row(glyph_row),
        .glyph_bits(glyph_bits), .digit_sel(digit_sel), .row_sel(row_sel),
        .col_drive(col_drive), .duty_gate(duty_gate)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_now(bit first);
        int ph, dg, rw, lvl, thr, ecols;
        bit vis;
        logic [7:0] chr;
        string tag, pre;
        ph  = tcnt % 8;
        dg  = (tcnt / 8) % 4;
        rw  = (tcnt / 32) % 7;
        vis = ((tcnt / DIV) % 2) == 0;
        chr = char_codes[dg*8 +: 8];
        pre = (tcnt == 0) ? "R11 " : (first ? "R12 " : "");
        chk({pre, "R1 digit"}, int'(digit_sel), dg);
        chk({pre, "R1 row"}, int'(row_sel), rw);
        chk({pre, "R2 code"}, int'(glyph_code), int'(chr[6:0]));
        chk({pre, "R2 row port"}, int'(glyph_row), rw);
        case (bright)
            2'b11: lvl = 8;
            2'b10: lvl = 4;
            2'b01: lvl = 2;
            default: lvl = 0;
        endcase
        if (lamp_test) begin
            ecols = 31; thr = 4; tag = "R10 lamp";
        end else if (blink_all && !vis) begin
            ecols = 0; thr = 0; tag = "R9 R8 global blink";
        end else if (chr[7] && hl_en) begin
            case (hl_mode)
                2'b00: begin ecols = 31; thr = lvl / 2; tag = "R5 cursor"; end
                2'b01: begin
                    ecols = vis ? int'(chr[4:0] ^ 5'(rw * 5)) : 0;
                    thr = vis ? lvl : 0; tag = "R6 R8 blink char";
                end
                2'b10: begin
                    ecols = vis ? 31 : 0; thr = vis ? lvl / 2 : 0;
                    tag = "R7 R8 blink cursor";
                end
                default: begin
                    ecols = vis ? int'(chr[4:0] ^ 5'(rw * 5)) : 31;
                    thr = vis ? lvl : lvl / 2; tag = "R7 R8 alternate";
                end
            endcase
        end else begin
            ecols = int'(chr[4:0] ^ 5'(rw * 5)); thr = lvl;
            tag = "R4 R3 plain";
        end
        chk({pre, tag, " cols"}, int'(col_drive), ecols);
        chk({pre, tag, " gate"}, int'(duty_gate), int'(ph < thr));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int idx = 0; idx < 128; idx++) begin
            for (int cyc = 0; cyc < 400; cyc++) begin
                @(negedge clk);
                if (cyc == 0) begin
                    bright    = idx[1:0];
                    hl_mode   = idx[3:2];
                    hl_en     = idx[4];
                    blink_all = idx[5];
                    lamp_test = idx[6];
                    char_codes = (idx[0] ^ idx[2]) ? 32'h41FF80A5 : 32'hD354CF50;
                end
                // R11: periodic reset part-way through to re-align the blink
                rst = (idx % 8 == 0) && (cyc == 150);
                #1;
                check_now(cyc == 0);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule